// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one down-counting channel of a programmable interval timer. A single system clock drives all of its registers, and counting advances only on cycles where the tick enable input is high. A load strobe writes a new initial count together with an operating mode. A gate input can suspend counting or restart it, depending on the mode. The block drives a single output waveform and shows its current count value on a port.

The channel has six behaviours. The first is a single terminal-count event, where the output goes high and stays high. The second is a one-shot started by the gate. The third is a periodic rate generator that drops its output for one tick per period. The fourth is a square wave, where the counter steps down by two on each tick. The last two produce a one-tick strobe, started either by the load or by a gate edge. A loaded value of zero stands for a full count of 65536. Counting is binary only.

Top module: `tcc_channel`

## Requirements
- R1: A loaded count of 0 gives a full count of 65536. In mode 0 with the gate held high and a tick on every cycle, out_q stays low for exactly 65536 samples, starting with the sample taken one cycle after the load.
- R2: A load strobe with mode 0, 1, 2, 4 or 5 makes count_q equal load_val one cycle later. count_q changes only on cycles where tick_en, load_stb or a gate rising edge is present. After reset, count_q is 0 and out_q is 1.
- R3: Mode 0 (mode_sel=0). out_q goes low on load. While the gate is high, the count drops by one per tick. When a tick takes the count from 1 to 0, out_q goes high and stays high until the next load.
- R4: Mode 1 (mode_sel=1). A load does not change out_q and does not start the one-shot. A gate rising edge reloads the initial count and drives out_q low. out_q goes high when a tick takes the count from 1 to 0. The count drops on every tick whatever the gate level.
- R5: Mode 2 (mode_sel=2). While the gate is high, a tick at count 2 moves the count to 1 and drives out_q low. A tick at count 1 reloads the initial count and drives out_q high. A load of N therefore gives a period of N ticks with one tick low.
- R6: Mode 3 (mode_sel=3). The counter drops by two per tick. For an even N, each half-period lasts N/2 ticks. For an odd N, the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks. out_q is high right after a load or a restart, and N must be at least 2.
- R7: Mode 4 (mode_sel=4). The count drops only while the gate is high. out_q is high after a load. out_q goes low for exactly one tick when a tick takes the count from 1 to 0, and this happens only once per load.
- R8: Mode 5 (mode_sel=5). A gate rising edge reloads the initial count and arms a single strobe. out_q goes low for one tick when a tick takes the count from 1 to 0. The count drops on every tick whatever the gate level.
- R9: In modes 0, 1, 4 and 5 the counter wraps from 0 to 0xFFFF and keeps counting, with no reload. There is no further out_q event until the next load or trigger.
- R10: A gate rising edge restarts the count only in modes 1, 2, 3 and 5. In modes 0 and 4 it only resumes counting.
- R11: mode_sel values 6 and 7 act exactly as modes 2 and 3.
- R12: In modes 2 and 3, a low gate freezes the count and forces out_q high.
- R13: A load takes priority over a gate rising edge and over a tick in the same cycle. After a load in any mode other than 0, out_q is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counting tick, one cycle wide per count step |
| gate | input | 1 | Gate level; rising edges are detected inside |
| load_stb | input | 1 | Writes load_val and mode_sel |
| load_val | input | 16 | Initial count (0 means 65536) |
| mode_sel | input | 3 | Operating mode code |
| out_q | output | 1 | Channel output waveform |
| count_q | output | 16 | Live counter value |

## Verification
The hardest situations to reach are the ones that come late in a count or that overlap in time. Examples are the 65536-tick sequence after a zero load, the wrap past zero in the one-shot modes, and a load that arrives in the same cycle as a gate rising edge. Directed runs create these on purpose. The run for the zero load holds tick_en high through the whole count. The collision test raises the gate on the exact cycle of the load. Random segments then mix short loads, sparse ticks and gate toggles across all eight mode codes. A bench model predicts count_q and out_q for every cycle of these segments.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [2:0] {
    MD_ONESHOT = 3'd0,
    MD_RETRIG  = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_SWSTB   = 3'd4,
    MD_HWSTB   = 3'd5
  } tcc_mode_e;

  // Codes 6 and 7 fold onto the periodic modes.
  function automatic tcc_mode_e fold_mode(input logic [2:0] raw);
    case (raw)
      3'd6:    return MD_RATE;
      3'd7:    return MD_SQUARE;
      default: return tcc_mode_e'(raw);
    endcase
  endfunction

  function automatic logic gate_restarts(input tcc_mode_e m);
    return (m == MD_RETRIG) || (m == MD_RATE) || (m == MD_SQUARE) || (m == MD_HWSTB);
  endfunction

  // Modes whose count ignores the gate level.
  function automatic logic gate_level_free(input tcc_mode_e m);
    return (m == MD_RETRIG) || (m == MD_HWSTB);
  endfunction

  function automatic logic is_periodic(input tcc_mode_e m);
    return (m == MD_RATE) || (m == MD_SQUARE);
  endfunction

  function automatic logic is_strobe(input tcc_mode_e m);
    return (m == MD_SWSTB) || (m == MD_HWSTB);
  endfunction

endpackage

// File: rtl/tcc_setup.sv
module tcc_setup
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_sel,
  input  logic          gate,
  output tcc_mode_e     load_mode,
  output tcc_mode_e     mode_q,
  output logic [CW-1:0] init_q,
  output logic          gate_rise
);

  logic gate_q;

  assign load_mode = fold_mode(mode_sel);
  assign gate_rise = gate && !gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_ONESHOT;
      init_q <= '0;
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate;
      if (load_stb) begin
        mode_q <= load_mode;
        init_q <= load_val;
      end
    end
  end

  // R11: alias codes land on the periodic modes
  a_r11_alias_fold: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && (mode_sel[2:1] == 2'b11)
    |=> mode_q == ($past(mode_sel[0]) ? MD_SQUARE : MD_RATE));

endmodule

// File: rtl/tcc_count_core.sv
module tcc_count_core
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  tcc_mode_e     load_mode,
  input  tcc_mode_e     mode_q,
  input  logic [CW-1:0] init_q,
  input  logic          gate,
  input  logic          gate_rise,
  input  logic          tick_en,
  input  logic          out_q,
  output logic [CW-1:0] count_q,
  output logic          restart,
  output logic          step,
  output logic          ev_zero,
  output logic          ev_near,
  output logic          ev_reload,
  output logic          ev_half
);

  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] cnt_nx;

  // Start of a half-phase; odd square-wave counts are skewed toward high.
  function automatic logic [CW-1:0] phase_start(input tcc_mode_e m,
                                                 input logic [CW-1:0] n,
                                                 input logic hi);
    if (m == MD_SQUARE && n[0])
      return hi ? (n + ONE) : (n - ONE);
    return n;
  endfunction

  assign restart = gate_rise && gate_restarts(mode_q) && !load_stb;
  assign step    = tick_en && !load_stb && !restart &&
                   (gate || gate_level_free(mode_q));

  always_comb begin
    cnt_nx    = count_q;
    ev_zero   = 1'b0;
    ev_near   = 1'b0;
    ev_reload = 1'b0;
    ev_half   = 1'b0;
    if (load_stb) begin
      cnt_nx = phase_start(load_mode, load_val, 1'b1);
    end else if (restart) begin
      cnt_nx = phase_start(mode_q, init_q, 1'b1);
    end else if (step) begin
      case (mode_q)
        MD_RATE: begin
          if (count_q == ONE) begin
            cnt_nx    = init_q;
            ev_reload = 1'b1;
          end else begin
            cnt_nx  = count_q - ONE;
            ev_near = (count_q == TWO);
          end
        end
        MD_SQUARE: begin
          if (count_q == TWO) begin
            cnt_nx  = phase_start(mode_q, init_q, !out_q);
            ev_half = 1'b1;
          end else begin
            cnt_nx = count_q - TWO;
          end
        end
        default: begin
          cnt_nx  = count_q - ONE;
          ev_zero = (count_q == ONE);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= cnt_nx;
  end

  // R2: no tick, no load, no gate edge -> count holds
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en && !load_stb && !gate_rise |=> $stable(count_q));

  // R12: gate low freezes periodic modes
  a_r12_gate_low_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    is_periodic(mode_q) && !gate && !load_stb |=> $stable(count_q));

  // R9: one-shot family wraps past zero
  a_r9_wrap_past_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !is_periodic(mode_q) && step && (count_q == '0) |=> count_q == '1);

  // R10: gate edge in modes 0/4 with no tick leaves the count alone
  a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_ONESHOT || mode_q == MD_SWSTB) && gate_rise && !load_stb && !tick_en
    |=> $stable(count_q));

endmodule

// File: rtl/tcc_out_ctl.sv
module tcc_out_ctl
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_stb,
  input  tcc_mode_e     load_mode,
  input  tcc_mode_e     mode_q,
  input  logic          gate,
  input  logic          restart,
  input  logic          step,
  input  logic          ev_zero,
  input  logic          ev_near,
  input  logic          ev_reload,
  input  logic          ev_half,
  input  logic [CW-1:0] count_q,
  output logic          out_q
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q   <= 1'b1;
      armed_q <= 1'b0;
    end else if (load_stb) begin
      out_q   <= (load_mode != MD_ONESHOT);
      armed_q <= (load_mode == MD_ONESHOT) || (load_mode == MD_SWSTB);
    end else if (restart) begin
      out_q <= (mode_q != MD_RETRIG);
      if (mode_q == MD_RETRIG || mode_q == MD_HWSTB) armed_q <= 1'b1;
    end else if (is_periodic(mode_q) && !gate) begin
      out_q <= 1'b1;
    end else if (step) begin
      case (mode_q)
        MD_ONESHOT, MD_RETRIG: begin
          if (armed_q && ev_zero) begin
            out_q   <= 1'b1;
            armed_q <= 1'b0;
          end
        end
        MD_SWSTB, MD_HWSTB: begin
          if (armed_q && ev_zero) begin
            out_q   <= 1'b0;
            armed_q <= 1'b0;
          end else begin
            out_q <= 1'b1;
          end
        end
        MD_RATE: begin
          if (ev_near)        out_q <= 1'b0;
          else if (ev_reload) out_q <= 1'b1;
        end
        MD_SQUARE: begin
          if (ev_half) out_q <= !out_q;
        end
        default: out_q <= out_q;
      endcase
    end
  end

  // R3: mode 0 load drops the output
  a_r3_load_low: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && (load_mode == MD_ONESHOT) |=> !out_q);

  // R13: any other load leaves the output high
  a_r13_load_high: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && (load_mode != MD_ONESHOT) |=> out_q);

  // R7: strobe lasts a single tick
  a_r7_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    is_strobe(mode_q) && !out_q && step |=> out_q);

  // R5: rate output is low only at count 1
  a_r5_low_at_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE) && !out_q |-> count_q == CW'(1));

  // R6: square wave flips when a half-phase ends
  a_r6_flip_at_two: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SQUARE) && step && (count_q == CW'(2)) |=> out_q != $past(out_q));

endmodule

// File: rtl/tcc_channel.sv
module tcc_channel
  import tcc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          gate,
  input  logic          load_stb,
  input  logic [CW-1:0] load_val,
  input  logic [2:0]    mode_sel,
  output logic          out_q,
  output logic [CW-1:0] count_q
);

  tcc_mode_e     load_mode;
  tcc_mode_e     mode_q;
  logic [CW-1:0] init_q;
  logic          gate_rise;
  logic          restart;
  logic          step;
  logic          ev_zero;
  logic          ev_near;
  logic          ev_reload;
  logic          ev_half;

  tcc_setup #(.CW(CW)) setup_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .mode_sel  (mode_sel),
    .gate      (gate),
    .load_mode (load_mode),
    .mode_q    (mode_q),
    .init_q    (init_q),
    .gate_rise (gate_rise)
  );

  tcc_count_core #(.CW(CW)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .load_val  (load_val),
    .load_mode (load_mode),
    .mode_q    (mode_q),
    .init_q    (init_q),
    .gate      (gate),
    .gate_rise (gate_rise),
    .tick_en   (tick_en),
    .out_q     (out_q),
    .count_q   (count_q),
    .restart   (restart),
    .step      (step),
    .ev_zero   (ev_zero),
    .ev_near   (ev_near),
    .ev_reload (ev_reload),
    .ev_half   (ev_half)
  );

  tcc_out_ctl #(.CW(CW)) outc_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_stb  (load_stb),
    .load_mode (load_mode),
    .mode_q    (mode_q),
    .gate      (gate),
    .restart   (restart),
    .step      (step),
    .ev_zero   (ev_zero),
    .ev_near   (ev_near),
    .ev_reload (ev_reload),
    .ev_half   (ev_half),
    .count_q   (count_q),
    .out_q     (out_q)
  );

  // R1: a zero load arms the full-range count in the one-shot modes
  a_r1_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb && (load_val == '0) && (mode_sel == 3'd0) |=> count_q == '0 && !out_q);

endmodule

// File: tb/tcc_channel_tb_top.sv
`timescale 1ns/1ps
module tcc_channel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        gate = 1'b0;
  logic        load_stb = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode_sel = '0;
  logic        out_q;
  logic [15:0] count_q;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench model of the channel
  int          m_mode = 0;
  logic [15:0] m_cnt = '0;
  logic [15:0] m_init = '0;
  logic        m_out = 1'b1;
  logic        m_arm = 1'b0;
  logic        m_gprev = 1'b0;

  always #5 clk = ~clk;

  tcc_channel dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .gate(gate),
    .load_stb(load_stb), .load_val(load_val), .mode_sel(mode_sel),
    .out_q(out_q), .count_q(count_q)
  );

  function automatic string mode_tag(int md);
    case (md)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      3: return "R6";
      4: return "R7";
      default: return "R8";
    endcase
  endfunction

  // first value of a half-phase, odd square counts skewed up for the high half
  function automatic logic [15:0] half_first(logic [15:0] n, int md, bit hi);
    if (md == 3 && (n % 2) == 1) return hi ? n + 16'd1 : n - 16'd1;
    return n;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(bit ld, logic [15:0] lv, int lm, bit g, bit tk, string tag);
    bit rise;
    string tg;
    load_stb = ld; load_val = lv; mode_sel = lm[2:0]; gate = g; tick_en = tk;
    rise = g && !m_gprev;
    m_gprev = g;
    if (ld) begin
      m_mode = (lm >= 6) ? lm - 4 : lm;
      m_init = lv;
      m_cnt  = half_first(lv, m_mode, 1'b1);
      m_out  = (m_mode != 0);
      m_arm  = (m_mode == 0 || m_mode == 4);
    end else if (rise && (m_mode == 1 || m_mode == 2 || m_mode == 3 || m_mode == 5)) begin
      m_cnt = half_first(m_init, m_mode, 1'b1);
      m_out = (m_mode != 1);
      if (m_mode == 1 || m_mode == 5) m_arm = 1'b1;
    end else if ((m_mode == 2 || m_mode == 3) && !g) begin
      m_out = 1'b1;
    end else if (tk && (g || m_mode == 1 || m_mode == 5)) begin
      case (m_mode)
        2: begin
          if (m_cnt == 16'd1) begin m_cnt = m_init; m_out = 1'b1; end
          else begin
            if (m_cnt == 16'd2) m_out = 1'b0;
            m_cnt = m_cnt - 16'd1;
          end
        end
        3: begin
          if (m_cnt == 16'd2) begin
            m_out = !m_out;
            m_cnt = half_first(m_init, 3, m_out);
          end else m_cnt = m_cnt - 16'd2;
        end
        4, 5: begin
          if (m_arm && m_cnt == 16'd1) begin m_out = 1'b0; m_arm = 1'b0; end
          else m_out = 1'b1;
          m_cnt = m_cnt - 16'd1;
        end
        default: begin
          if (m_arm && m_cnt == 16'd1) begin m_out = 1'b1; m_arm = 1'b0; end
          m_cnt = m_cnt - 16'd1;
        end
      endcase
    end
    @(negedge clk);
    load_stb = 1'b0;
    tg = (tag != "") ? tag : mode_tag(m_mode);
    chk(count_q == m_cnt, tg, "count", count_q, m_cnt);
    chk(out_q == m_out, tg, "out", out_q, m_out);
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    bit g;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(count_q == 16'd0, "R2", "reset count", count_q, 0);
    chk(out_q == 1'b1, "R2", "reset out", out_q, 1);

    // R1: zero load spans 65536 ticks in mode 0
    drive(1, 16'd0, 0, 1, 1, "R1");
    chk(count_q == 16'd0 && out_q == 1'b0, "R1", "after zero load", {out_q, count_q}, 0);
    n = 1;
    while (out_q == 1'b0 && n < 70000) begin
      drive(0, 16'd0, 0, 1, 1, "R1");
      if (out_q == 1'b0) n++;
    end
    chk(n == 65536, "R1", "low span", n, 65536);

    // R2: load visible, no change without ticks
    drive(1, 16'd23, 4, 1, 0, "R2");
    chk(count_q == 16'd23, "R2", "loaded value", count_q, 23);
    drive(0, 16'd0, 0, 1, 0, "R2");
    chk(count_q == 16'd23, "R2", "idle hold", count_q, 23);

    // R9: mode 4 wraps with no second strobe
    drive(1, 16'd2, 4, 1, 1, "R9");
    drive(0, 16'd0, 0, 1, 1, "R9");
    drive(0, 16'd0, 0, 1, 1, "R9");
    chk(out_q == 1'b0 && count_q == 16'd0, "R9", "strobe at zero", {out_q, count_q}, 0);
    drive(0, 16'd0, 0, 1, 1, "R9");
    chk(count_q == 16'hFFFF && out_q == 1'b1, "R9", "wrapped", {out_q, count_q}, 32'h1FFFF);

    // R10: gate edge in mode 0 does not restart
    drive(1, 16'd10, 0, 1, 1, "R10");
    repeat (3) drive(0, 16'd0, 0, 1, 1, "R10");
    drive(0, 16'd0, 0, 0, 1, "R10");
    drive(0, 16'd0, 0, 1, 1, "R10");
    chk(count_q == 16'd6, "R10", "no restart", count_q, 6);

    // R6: odd square wave N=7 -> 4 high, 3 low
    drive(1, 16'd7, 3, 1, 1, "R6");
    n = 1;
    while (out_q && n < 20) begin drive(0, 16'd0, 0, 1, 1, "R6"); if (out_q) n++; end
    chk(n == 4, "R6", "high half", n, 4);
    n = 1;
    while (!out_q && n < 20) begin drive(0, 16'd0, 0, 1, 1, "R6"); if (!out_q) n++; end
    chk(n == 3, "R6", "low half", n, 3);

    // R12: gate low freezes and forces high
    drive(0, 16'd0, 0, 1, 1, "R12");
    drive(0, 16'd0, 0, 0, 1, "R12");
    n = count_q;
    drive(0, 16'd0, 0, 0, 1, "R12");
    drive(0, 16'd0, 0, 0, 1, "R12");
    chk(count_q == n[15:0] && out_q, "R12", "frozen", count_q, n);

    // R11: code 6 behaves as rate generator
    drive(1, 16'd3, 6, 1, 1, "R11");
    drive(0, 16'd0, 0, 1, 1, "R11");
    drive(0, 16'd0, 0, 1, 1, "R11");
    chk(out_q == 1'b0 && count_q == 16'd1, "R11", "rate low at 1", {out_q, count_q}, 1);
    drive(0, 16'd0, 0, 1, 1, "R11");
    chk(out_q == 1'b1 && count_q == 16'd3, "R11", "rate reload", {out_q, count_q}, 32'h10003);

    // R13: load beats a simultaneous gate edge in mode 1
    drive(0, 16'd0, 0, 0, 0, "R13");
    drive(1, 16'd5, 1, 1, 1, "R13");
    chk(out_q == 1'b1 && count_q == 16'd5, "R13", "load wins", {out_q, count_q}, 32'h10005);
    drive(0, 16'd0, 0, 1, 1, "R13");
    chk(out_q == 1'b1 && count_q == 16'd4, "R13", "no trigger", {out_q, count_q}, 32'h10004);

    // R4 / R8: gate triggers
    drive(0, 16'd0, 0, 0, 0, "R4");
    drive(0, 16'd0, 0, 1, 0, "R4");
    chk(out_q == 1'b0 && count_q == 16'd5, "R4", "trigger", {out_q, count_q}, 5);
    drive(1, 16'd2, 5, 0, 0, "R8");
    drive(0, 16'd0, 0, 1, 1, "R8");
    drive(0, 16'd0, 0, 1, 1, "R8");
    drive(0, 16'd0, 0, 1, 1, "R8");
    chk(out_q == 1'b0 && count_q == 16'd0, "R8", "hw strobe", {out_q, count_q}, 0);

    // random mix over all codes
    g = 1'b1;
    for (int i = 0; i < 25000; i++) begin
      bit ld;
      int lm;
      ld = ($urandom_range(0, 63) == 0);
      lm = $urandom_range(0, 7);
      if ($urandom_range(0, 15) == 0) g = !g;
      drive(ld, 16'($urandom_range(2, 40)), lm, g, $urandom_range(0, 3) != 0, "");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule